// File: doc/BRIEF.md
# Multiplexed External Memory Bus Master

This block runs read and write cycles on an external data-memory bus where one 8-bit port carries, at different times, the low address byte and the data. A separate 8-bit port carries the upper address byte. The low byte has to be caught by an 8-bit latch outside the block. The block drives a latch strobe for that latch, and the memory is selected through active-low read and write strobes. The shared port is driven through an output value, an output enable and an input value, so a tristate pad can be built around it.

The host raises `req_valid` with a direction flag, an address and write data. The request is taken only while `req_ready` is high. After a fixed number of clocks the block raises `rsp_done` for one cycle. After a read, `rsp_rdata` holds the byte it captured. A page mode takes only the low byte from the request and leaves the high port unchanged. The caller can then walk a 256-byte page, which was selected by an earlier full-address access, without sending the upper byte again. Every bus phase lasts `PH_CYC` clocks.

Top module: `xbus_master`

## Requirements
- R1: After reset, and whenever no access is running, `bus_ale`=0, `bus_rd_n`=1, `bus_wr_n`=1, `bus_ad_oe`=0 and `req_ready`=1. After reset `bus_hi`=0.
- R2: A read runs these phases, each `PH_CYC` clocks long: latch strobe high with the low address driven, latch strobe low with the low address held, port released, read strobe low. `rsp_done` rises in the 4*PH_CYC+1-th cycle after the accepting clock edge, counting the cycle that starts at that edge as the first.
- R3: A write runs these phases, each `PH_CYC` clocks long: latch strobe high with the low address, address hold, data driven, write strobe low with the data driven, write strobe high with the data still driven. `rsp_done` rises in the 5*PH_CYC+1-th cycle after acceptance.
- R4: While `bus_ale` is high and when it falls, the shared port drives `req_addr[7:0]`. `bus_hi` does not change while `bus_ale` is high. In full-address mode (`req_short`=0), `bus_hi` takes `req_addr[15:8]` right after the latch strobe falls.
- R5: The shared port is released (`bus_ad_oe`=0) in every cycle where `bus_rd_n` is low.
- R6: `bus_rd_n` and `bus_wr_n` are never low in the same cycle, and neither is low while `bus_ale` is high.
- R7: In page mode (`req_short`=1), `bus_hi` keeps its earlier value for the whole access. The memory location used is {`bus_hi`, `req_addr[7:0]`}.
- R8: Read data is the value on `bus_ad_in` in the last cycle of the read strobe. It appears on `rsp_rdata` with `rsp_done` and stays there until the next read finishes.
- R9: `rsp_done` is high for exactly one cycle per access.
- R10: A request made while `req_ready` is low is ignored: it starts no bus cycle and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when `req_ready` is high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_short | input | 1 | 1 = page mode (low byte only) |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Block idle, a request can be taken |
| rsp_rdata | output | 8 | Last byte read |
| rsp_done | output | 1 | One-cycle end-of-access strobe |
| bus_ad_out | output | 8 | Shared port output value |
| bus_ad_oe | output | 1 | Shared port output enable |
| bus_ad_in | input | 8 | Shared port input value |
| bus_hi | output | 8 | Upper address byte |
| bus_ale | output | 1 | Low-address latch strobe, active high |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |

## Verification
Two functions can coincide in one cycle. The first is the done cycle of one access. The second is a request that is still held from the busy period. The done cycle is already idle, so a request that stays up into that cycle would start a new access at the next edge. The bench holds a second write request high through the whole of a first write and drops it only in the cycle that shows `rsp_done`. It then expects exactly one done, the normal write latency, no change at the second address, and no latch strobe afterwards.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ALE,
    PH_HOLD,
    PH_TURN,
    PH_RSTB,
    PH_WDAT,
    PH_WSTB,
    PH_WREC
  } phase_e;
endpackage

// File: rtl/xbus_phase_timer.sv
module xbus_phase_timer #(
  parameter int PH_CYC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic last
);
  localparam int CW = (PH_CYC > 1) ? $clog2(PH_CYC) : 1;
  localparam logic [CW-1:0] LAST_V = CW'(PH_CYC - 1);

  logic [CW-1:0] cnt;

  assign last = (cnt == LAST_V);

  always_ff @(posedge clk) begin
    if (rst || restart) cnt <= '0;
    else if (!last)     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   req_valid,
  input  logic   req_write,
  input  logic   last,
  output phase_e phase,
  output phase_e nxt,
  output logic   accept,
  output logic   restart,
  output logic   finish
);
  logic is_wr;

  assign accept  = (phase == PH_IDLE) && req_valid;
  assign restart = (nxt != phase);
  assign finish  = last && ((phase == PH_RSTB) || (phase == PH_WREC));

  always_comb begin
    nxt = phase;
    unique case (phase)
      PH_IDLE: if (req_valid) nxt = PH_ALE;
      PH_ALE:  if (last) nxt = PH_HOLD;
      PH_HOLD: if (last) nxt = is_wr ? PH_WDAT : PH_TURN;
      PH_TURN: if (last) nxt = PH_RSTB;
      PH_RSTB: if (last) nxt = PH_IDLE;
      PH_WDAT: if (last) nxt = PH_WSTB;
      PH_WSTB: if (last) nxt = PH_WREC;
      PH_WREC: if (last) nxt = PH_IDLE;
      default: nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      is_wr <= 1'b0;
    end else begin
      phase <= nxt;
      if (accept) is_wr <= req_write;
    end
  end

  // R2 / R3: the end of an access always returns the sequencer to idle
  p_finish_idle_r9: assert property (@(posedge clk) disable iff (rst)
    finish |=> (phase == PH_IDLE));
endmodule

// File: rtl/xbus_pins.sv
module xbus_pins
  import xbus_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  logic          req_short,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  phase_e        phase,
  input  phase_e        nxt,
  input  logic          finish,
  input  logic [DW-1:0] ad_in,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  output logic [AW-DW-1:0] hi,
  output logic          ale,
  output logic          rd_n,
  output logic          wr_n,
  output logic [DW-1:0] rdata,
  output logic          done
);
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic          short_q;
  logic          data_ph;
  logic          drive_nxt;

  assign data_ph   = (nxt == PH_WDAT) || (nxt == PH_WSTB) || (nxt == PH_WREC);
  assign drive_nxt = data_ph || (nxt == PH_ALE) || (nxt == PH_HOLD);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      wdata_q <= '0;
      short_q <= 1'b0;
      ad_out  <= '0;
      ad_oe   <= 1'b0;
      hi      <= '0;
      ale     <= 1'b0;
      rd_n    <= 1'b1;
      wr_n    <= 1'b1;
      rdata   <= '0;
      done    <= 1'b0;
    end else begin
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        short_q <= req_short;
        ad_out  <= req_addr[DW-1:0];
      end else if (data_ph) begin
        ad_out  <= wdata_q;
      end else begin
        ad_out  <= addr_q[DW-1:0];
      end
      ad_oe <= drive_nxt;
      ale   <= (nxt == PH_ALE);
      rd_n  <= (nxt != PH_RSTB);
      wr_n  <= (nxt != PH_WSTB);
      if (phase == PH_ALE && nxt == PH_HOLD && !short_q)
        hi <= addr_q[AW-1:DW];
      if (phase == PH_RSTB && finish)
        rdata <= ad_in;
      done <= finish;
    end
  end

  p_released_r5: assert property (@(posedge clk) disable iff (rst)
    !rd_n |-> !ad_oe);
  p_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(!rd_n && !wr_n) && !(ale && (!rd_n || !wr_n)));
  p_hi_steady_r4: assert property (@(posedge clk) disable iff (rst)
    ale |-> $stable(hi));
  p_capture_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_n) |-> (rdata == $past(ad_in)));
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_page_hi_r7: assert property (@(posedge clk) disable iff (rst)
    (short_q && phase != PH_IDLE && !accept) |-> $stable(hi));
endmodule

// File: rtl/xbus_master.sv
module xbus_master
  import xbus_pkg::*;
#(
  parameter int PH_CYC = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic        req_short,
  input  logic [15:0] req_addr,
  input  logic [7:0]  req_wdata,
  output logic        req_ready,
  output logic [7:0]  rsp_rdata,
  output logic        rsp_done,
  output logic [7:0]  bus_ad_out,
  output logic        bus_ad_oe,
  input  logic [7:0]  bus_ad_in,
  output logic [7:0]  bus_hi,
  output logic        bus_ale,
  output logic        bus_rd_n,
  output logic        bus_wr_n
);
  phase_e phase, nxt;
  logic   last, accept, restart, finish;

  xbus_phase_timer #(.PH_CYC(PH_CYC)) u_tmr (
    .clk(clk), .rst(rst), .restart(restart), .last(last)
  );

  xbus_seq u_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .last(last), .phase(phase), .nxt(nxt), .accept(accept),
    .restart(restart), .finish(finish)
  );

  xbus_pins #(.AW(16), .DW(8)) u_pins (
    .clk(clk), .rst(rst), .accept(accept), .req_short(req_short),
    .req_addr(req_addr), .req_wdata(req_wdata), .phase(phase), .nxt(nxt),
    .finish(finish), .ad_in(bus_ad_in), .ad_out(bus_ad_out),
    .ad_oe(bus_ad_oe), .hi(bus_hi), .ale(bus_ale), .rd_n(bus_rd_n),
    .wr_n(bus_wr_n), .rdata(rsp_rdata), .done(rsp_done)
  );

  assign req_ready = (phase == PH_IDLE);

  p_start_idle_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_ale) |-> $past(req_ready));
  p_idle_pins_r1: assert property (@(posedge clk) disable iff (rst)
    (req_ready && !rsp_done) |-> (!bus_ale && bus_rd_n && bus_wr_n && !bus_ad_oe));
endmodule

// File: tb/xbus_master_tb_top.sv
`timescale 1ns/1ps
module xbus_master_tb_top;
  localparam int P = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0, req_short = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready, rsp_done, bus_ad_oe, bus_ale, bus_rd_n, bus_wr_n;
  logic [7:0] rsp_rdata, bus_ad_out, bus_hi;
  logic [7:0] bus_ad_in = '0;

  int n_chk = 0, n_bad = 0;
  int n_done = 0, n_wr = 0, n_ale = 0, n_viol = 0;
  logic [7:0] lat_lo = '0;
  logic prev_ale = 1'b0, prev_wr_n = 1'b1, prev_done = 1'b0;
  logic [7:0] prev_hi = '0;
  logic [7:0] mem [int];

  always #2 clk = ~clk;

  xbus_master #(.PH_CYC(P)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_short(req_short), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .rsp_rdata(rsp_rdata), .rsp_done(rsp_done),
    .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe), .bus_ad_in(bus_ad_in),
    .bus_hi(bus_hi), .bus_ale(bus_ale), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n)
  );

  function automatic logic [7:0] peek(int a);
    return mem.exists(a) ? mem[a] : 8'hEE;
  endfunction

  // External latch + memory model, sampled mid-cycle
  always @(negedge clk) begin
    if (!rst) begin
      if (prev_ale && !bus_ale) begin
        lat_lo = bus_ad_out;
        n_ale++;
      end
      if (!prev_wr_n && bus_wr_n) begin
        mem[{bus_hi, lat_lo}] = bus_ad_out;
        n_wr++;
      end
      if (!bus_rd_n) bus_ad_in <= peek({bus_hi, lat_lo});
      else           bus_ad_in <= 8'h00;
      if (!bus_rd_n && bus_ad_oe) n_viol++;
      if (!bus_rd_n && !bus_wr_n) n_viol++;
      if (bus_ale && (!bus_rd_n || !bus_wr_n)) n_viol++;
      if (bus_ale && prev_ale && bus_hi != prev_hi) n_viol++;
      if (bus_ale && !bus_ad_oe) n_viol++;
      if (rsp_done) n_done++;
      if (rsp_done && prev_done) n_viol++;
    end
    prev_ale  = bus_ale;
    prev_wr_n = bus_wr_n;
    prev_hi   = bus_hi;
    prev_done = rsp_done;
  end

  task automatic check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_op(bit wr, bit sh, logic [15:0] a, logic [7:0] d,
                       output int cyc);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_short = sh;
    req_addr = a; req_wdata = d;
    @(posedge clk);
    cyc = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      req_valid = 1'b0;
      cyc++;
      if (rsp_done) break;
    end
  endtask

  task automatic t_reset;
    check(!bus_ale && bus_rd_n && bus_wr_n && !bus_ad_oe && req_ready,
          "R1 idle pins", {bus_ale, bus_rd_n, bus_wr_n, bus_ad_oe, req_ready}, 5'b01101);
    check(bus_hi == 8'h00, "R1 hi after reset", bus_hi, 0);
  endtask

  task automatic t_read_full;
    int c, v0;
    mem[16'h5A10] = 8'hC3;
    v0 = n_ale;
    do_op(1'b0, 1'b0, 16'h5A10, 8'h00, c);
    check(c == 4*P+1, "R2 read latency", c, 4*P+1);
    check(rsp_rdata == 8'hC3, "R8 read data", rsp_rdata, 8'hC3);
    check(lat_lo == 8'h10, "R4 latched low", lat_lo, 8'h10);
    check(bus_hi == 8'h5A, "R4 hi updated", bus_hi, 8'h5A);
    check(n_ale == v0 + 1, "R2 one latch pulse", n_ale - v0, 1);
  endtask

  task automatic t_write_full;
    int c, w0;
    w0 = n_wr;
    do_op(1'b1, 1'b0, 16'h1234, 8'hA5, c);
    check(c == 5*P+1, "R3 write latency", c, 5*P+1);
    check(peek(16'h1234) == 8'hA5, "R3 write stored", peek(16'h1234), 8'hA5);
    check(n_wr == w0 + 1, "R3 one write strobe", n_wr - w0, 1);
    check(rsp_rdata == 8'hC3, "R8 rdata held over write", rsp_rdata, 8'hC3);
    check(!bus_ad_oe && bus_wr_n, "R1 idle after write", {bus_ad_oe, bus_wr_n}, 2'b01);
  endtask

  task automatic t_page;
    int c;
    mem[16'h0033] = 8'h44;
    do_op(1'b0, 1'b0, 16'h7E01, 8'h00, c);
    do_op(1'b1, 1'b1, 16'h0033, 8'h77, c);
    check(bus_hi == 8'h7E, "R7 hi kept", bus_hi, 8'h7E);
    check(peek(16'h7E33) == 8'h77, "R7 page write", peek(16'h7E33), 8'h77);
    check(peek(16'h0033) == 8'h44, "R7 other page untouched", peek(16'h0033), 8'h44);
    mem[16'h7E90] = 8'h5C;
    do_op(1'b0, 1'b1, 16'hFF90, 8'h00, c);
    check(rsp_rdata == 8'h5C, "R7 page read", rsp_rdata, 8'h5C);
    check(c == 4*P+1, "R7 page read latency", c, 4*P+1);
  endtask

  task automatic t_busy;
    int c, d0, a0;
    mem[16'h2200] = 8'h11;
    mem[16'h4321] = 8'h22;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_short = 1'b0;
    req_addr = 16'h2200; req_wdata = 8'h99;
    @(posedge clk);
    d0 = n_done; a0 = n_ale;
    @(negedge clk);
    req_addr = 16'h4321; req_wdata = 8'h55;
    c = 1;
    for (int k = 0; k < 200; k++) begin
      if (rsp_done) break;
      @(negedge clk);
      c++;
    end
    req_valid = 1'b0;
    repeat (3*P) @(negedge clk);
    check(c == 5*P+1, "R10 latency with held request", c, 5*P+1);
    check(peek(16'h2200) == 8'h99, "R10 first write", peek(16'h2200), 8'h99);
    check(peek(16'h4321) == 8'h22, "R10 busy request ignored", peek(16'h4321), 8'h22);
    check(n_done == d0 + 1, "R9 single done", n_done - d0, 1);
    check(n_ale == a0 + 1 && !bus_ale, "R10 no extra cycle", n_ale - a0, 1);
  endtask

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_read_full();
    t_write_full();
    t_page();
    t_busy();
    check(n_viol == 0, "R5 R6 R9 bus rule monitor", n_viol, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule